// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block expands a 128-bit cipher key into the eleven round keys of the 128-bit variant of the cipher. It computes the keys on the fly and produces one complete 128-bit round key per accepted output transfer. It keeps no table of expanded keys. A one-cycle `start` pulse loads a new key. The block then offers round 0, which is the key itself, followed by rounds 1 through 10. Each round key appears on a valid/ready output together with its 4-bit round number.

Each round key is derived from the one before it. The last word of the previous key is rotated by one byte, passed through the byte substitution box and XORed with a round constant. The result is then folded through the four previous words as a chain of XORs. The S-box is held in a 256-entry ROM whose contents are computed at elaboration from the field inverse and the affine map. A small ROM indexed by round number supplies the round constant.

When round 10 has been accepted, the block pulses `done` and retains that key on `last_key`. An inverse cipher can start from this key. The output obeys back-pressure: while `rk_valid` is high and `rk_ready` is low, the offered key and its round number stay unchanged. The next key is computed only after a transfer completes. `start` is a plain control pin and takes priority over any pending transfer.

Top module: `aes128_keygen`

## Requirements
- R1: While `rst_n` is low and after its release, until the first `start`, `rk_valid` and `done` are 0 and `last_key` is all zeros.
- R2: The cycle after `start` is high, `rk_valid` is 1, `rk_round` is 0 and `rk_data` equals `key_in`. Key byte 0 (the first byte) sits in bits 127:120 and word w0 occupies bits 127:96.
- R3: After round r (r < 10) is accepted, the next key is formed as follows. Split the previous key into words p0..p3, with p0 in the top 32 bits. Let t = SubWord(RotWord(p3)) XOR {rc,24'h0}, where RotWord moves the top byte to the bottom. The new words are then n0 = p0^t, n1 = p1^n0, n2 = p2^n1 and n3 = p3^n2.
- R4: The round constant byte rc used to build round k (k = 1..10) is 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 in that order.
- R5: While `rk_valid` is 1 and `rk_ready` is 0, with no `start`, `rk_valid`, `rk_data` and `rk_round` keep their values on the next cycle.
- R6: A transfer happens on a clock edge where `rk_valid` and `rk_ready` are both 1. Each transfer of a round below 10 offers round+1 on the next cycle. With `rk_ready` held at 1, rounds 0..10 appear on 11 consecutive cycles.
- R7: On the cycle after round 10 is transferred, `rk_valid` is 0 and `done` is 1. `done` is 1 for that single cycle only.
- R8: `last_key` takes the transferred round-10 key in the cycle `done` rises. It holds that value until the next completed schedule, and a restart does not change it.
- R9: A `start` during generation discards the schedule in progress. The next cycle offers round 0 of the new key, even if a transfer happened on the same edge.
- R10: For key 000102030405060708090a0b0c0d0e0f, round 1 is d6aa74fdd2af72fadaa678f1d6ab76fe and round 10 is 13111d7fe3944a17f307a78b4d2b30c5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `key_in` and begin a schedule at round 0 |
| key_in | input | 128 | Cipher key, byte 0 in the top bits |
| rk_valid | output | 1 | A round key is offered |
| rk_ready | input | 1 | Consumer accepts the offered key |
| rk_data | output | 128 | Offered round key |
| rk_round | output | 4 | Round number of the offered key, 0..10 |
| done | output | 1 | One-cycle pulse after round 10 is transferred |
| last_key | output | 128 | Retained round-10 key of the last completed schedule |

## Verification
The properties assume that `rst_n` is low at time zero and that `start` and `rk_ready` are always driven to known levels. They make no assumption that the consumer keeps `rk_ready` high, or that `start` arrives only while the block is idle. The bench drives every input at the falling clock edge. It toggles `rk_ready` from a seeded random draw so that stalls land at every round, including round 10. It also issues one `start` in the middle of a schedule, on a cycle where a transfer is also pending, so that the priority of `start` is exercised.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 4 * BYTE_W;
  localparam int WORDS    = 4;
  localparam int KEY_W    = WORDS * WORD_W;
  localparam int RND_W    = 4;
  localparam int LAST_RND = 10;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [KEY_W-1:0]  rkey_t;
  typedef logic [RND_W-1:0]  rnd_t;

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring: product of a^(2^i) for i = 1..7
  function automatic byte_t gf_inv(byte_t a);
    byte_t acc = 8'h01;
    byte_t sq  = a;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic byte_t rotl8(byte_t v, int n);
    return byte_t'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic byte_t sbox_calc(byte_t a);
    byte_t q = gf_inv(a);
    return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
  import aes_ks_pkg::*;
(
  input  byte_t addr,
  output byte_t data
);
  localparam int DEPTH = 1 << BYTE_W;

  byte_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam byte_t ENTRY = sbox_calc(byte_t'(g));
    assign rom[g] = ENTRY;
  end

  assign data = rom[addr];
endmodule

// File: rtl/ks_rcon.sv
module ks_rcon
  import aes_ks_pkg::*;
(
  input  rnd_t  rnd,
  output byte_t rc
);
  always_comb begin
    unique case (rnd)
      4'd1:    rc = 8'h01;
      4'd2:    rc = 8'h02;
      4'd3:    rc = 8'h04;
      4'd4:    rc = 8'h08;
      4'd5:    rc = 8'h10;
      4'd6:    rc = 8'h20;
      4'd7:    rc = 8'h40;
      4'd8:    rc = 8'h80;
      4'd9:    rc = 8'h1b;
      4'd10:   rc = 8'h36;
      default: rc = 8'h00;
    endcase
  end
endmodule

// File: rtl/ks_round.sv
module ks_round
  import aes_ks_pkg::*;
(
  input  rkey_t prev_key,
  input  rnd_t  next_rnd,
  output rkey_t next_key
);
  word_t pw [WORDS];
  word_t nw [WORDS];
  word_t rot;
  word_t sub;
  word_t tmp;
  byte_t rc;

  for (genvar w = 0; w < WORDS; w++) begin : g_split
    assign pw[w] = prev_key[KEY_W-1-w*WORD_W -: WORD_W];
  end

  // byte rotation of the last word: top byte moves to the bottom
  assign rot = {pw[WORDS-1][WORD_W-BYTE_W-1:0], pw[WORDS-1][WORD_W-1 -: BYTE_W]};

  for (genvar b = 0; b < WORDS; b++) begin : g_sub
    ks_sbox u_sb (
      .addr (rot[b*BYTE_W +: BYTE_W]),
      .data (sub[b*BYTE_W +: BYTE_W])
    );
  end

  ks_rcon u_rc (
    .rnd (next_rnd),
    .rc  (rc)
  );

  assign tmp = sub ^ {rc, {(WORD_W-BYTE_W){1'b0}}};

  for (genvar w = 0; w < WORDS; w++) begin : g_chain
    if (w == 0) begin : g_first
      assign nw[w] = pw[w] ^ tmp;
    end else begin : g_rest
      assign nw[w] = pw[w] ^ nw[w-1];
    end
    assign next_key[KEY_W-1-w*WORD_W -: WORD_W] = nw[w];
  end
endmodule

// File: rtl/aes128_keygen.sv
module aes128_keygen
  import aes_ks_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] key_in,
  output logic         rk_valid,
  input  logic         rk_ready,
  output logic [127:0] rk_data,
  output logic [3:0]   rk_round,
  output logic         done,
  output logic [127:0] last_key
);
  localparam rnd_t FINAL = rnd_t'(LAST_RND);

  logic  valid_q;
  logic  done_q;
  rnd_t  rnd_q;
  rkey_t key_q;
  rkey_t last_q;
  rkey_t key_nx;
  rnd_t  rnd_nx;
  logic  xfer;

  assign xfer   = valid_q && rk_ready;
  assign rnd_nx = rnd_q + rnd_t'(1);

  ks_round u_step (
    .prev_key (key_q),
    .next_rnd (rnd_nx),
    .next_key (key_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      rnd_q   <= '0;
      key_q   <= '0;
      last_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        valid_q <= 1'b1;
        rnd_q   <= '0;
        key_q   <= key_in;
      end else if (xfer) begin
        if (rnd_q == FINAL) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
          last_q  <= key_q;
        end else begin
          rnd_q <= rnd_nx;
          key_q <= key_nx;
        end
      end
    end
  end

  assign rk_valid = valid_q;
  assign rk_data  = key_q;
  assign rk_round = rnd_q;
  assign done     = done_q;
  assign last_key = last_q;
endmodule

// File: rtl/aes128_keygen_chk.sv
module aes128_keygen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [127:0] key_in,
  input logic         rk_valid,
  input logic         rk_ready,
  input logic [127:0] rk_data,
  input logic [3:0]   rk_round,
  input logic         done,
  input logic [127:0] last_key
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !rk_valid && !done);

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rk_valid && rk_round == 4'd0 && rk_data == $past(key_in));

  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && !rk_ready && !start |=>
      rk_valid && $stable(rk_data) && $stable(rk_round));

  p_round_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && rk_ready && !start && rk_round != 4'd10 |=>
      rk_valid && rk_round == $past(rk_round) + 4'd1);

  p_round_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> rk_round <= 4'd10);

  p_done_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && rk_ready && !start && rk_round == 4'd10 |=> done && !rk_valid);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_last_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> last_key == $past(rk_data));

  p_last_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(last_key) || done);
endmodule

bind aes128_keygen aes128_keygen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .key_in   (key_in),
  .rk_valid (rk_valid),
  .rk_ready (rk_ready),
  .rk_data  (rk_data),
  .rk_round (rk_round),
  .done     (done),
  .last_key (last_key)
);

// File: tb/sim_aes128_keygen.sv
`timescale 1ns/1ps
module sim_aes128_keygen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key_in = '0;
  logic         rk_valid;
  logic         rk_ready = 1'b0;
  logic [127:0] rk_data;
  logic [3:0]   rk_round;
  logic         done;
  logic [127:0] last_key;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0]   sb [256];
  logic [127:0] last_exp = '0;

  always #5 clk = ~clk;

  aes128_keygen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .rk_valid(rk_valid), .rk_ready(rk_ready), .rk_data(rk_data),
    .rk_round(rk_round), .done(done), .last_key(last_key)
  );

  function automatic logic [7:0] xt(logic [7:0] v);
    return v[7] ? ((v << 1) ^ 8'h1b) : (v << 1);
  endfunction

  function automatic logic [7:0] rl(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // substitution box from exp/log tables of generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int lg [256];
    logic [7:0] p = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = p; lg[p] = i; p = p ^ xt(p);
    end
    for (int a = 0; a < 256; a++) begin
      logic [7:0] q;
      q = (a == 0) ? 8'h00 : ex[(255 - lg[a]) % 255];
      sb[a] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [127:0] next_key(logic [127:0] prev, int r);
    logic [7:0] rc = 8'h01;
    logic [31:0] w0, w1, w2, w3, t;
    for (int j = 1; j < r; j++) rc = xt(rc);
    {w0, w1, w2, w3} = prev;
    t = {sb[w3[23:16]], sb[w3[15:8]], sb[w3[7:0]], sb[w3[31:24]]} ^ {rc, 24'h0};
    w0 = w0 ^ t; w1 = w1 ^ w0; w2 = w2 ^ w1; w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Runs a schedule whose round 0 is already on the outputs (now at a negedge).
  // rnd_ready: random back-pressure; stop_at: abort before this round (>10 = full)
  task automatic stream(logic [127:0] k, bit rnd_ready, int stop_at);
    logic [127:0] exp = k;
    int r = 0;
    bit rdy;
    forever begin
      chk("R2/R6 valid", {127'd0, rk_valid}, 128'd1);
      chk("R6 round", {124'd0, rk_round}, 128'(r));
      chk("R3/R4 data", rk_data, exp);
      if (r == stop_at) return;
      rdy = rnd_ready ? ($urandom_range(3) != 0) : 1'b1;
      rk_ready = rdy;
      @(negedge clk);
      if (!rdy) begin
        chk("R5 stall data", rk_data, exp);
      end else if (r == 10) begin
        chk("R7 done", {127'd0, done}, 128'd1);
        chk("R7 valid low", {127'd0, rk_valid}, 128'd0);
        chk("R8 last_key", last_key, exp);
        last_exp = exp;
        rk_ready = 1'b0;
        @(negedge clk);
        chk("R7 done single", {127'd0, done}, 128'd0);
        chk("R8 last held", last_key, last_exp);
        return;
      end else begin
        r++;
        exp = next_key(exp, r);
      end
    end
  endtask

  task automatic kick(logic [127:0] k);
    key_in = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [127:0] fk;
    void'($urandom(32'h1234_5678));
    build_sbox();
    fk = 128'h000102030405060708090a0b0c0d0e0f;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {127'd0, rk_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", {127'd0, rk_valid}, 128'd0);
    chk("R1 done", {127'd0, done}, 128'd0);
    chk("R1 last_key", last_key, 128'd0);

    // R10: known key, round 1 and round 10 directed values, ready held high
    kick(fk);
    chk("R2 key load", rk_data, fk);
    rk_ready = 1'b1;
    @(negedge clk);
    chk("R10 round1", rk_data, 128'hd6aa74fdd2af72fadaa678f1d6ab76fe);
    for (int i = 2; i <= 10; i++) @(negedge clk);
    chk("R10 round10", rk_data, 128'h13111d7fe3944a17f307a78b4d2b30c5);
    chk("R6 consecutive", {124'd0, rk_round}, 128'd10);
    @(negedge clk);
    chk("R7 done", {127'd0, done}, 128'd1);
    chk("R8 last_key", last_key, 128'h13111d7fe3944a17f307a78b4d2b30c5);
    last_exp = last_key;
    rk_ready = 1'b0;
    @(negedge clk);

    // zero and all-ones keys under random stalls (R3, R4, R5)
    kick('0);
    stream('0, 1'b1, 99);
    kick('1);
    stream('1, 1'b1, 99);

    // R9: restart mid-schedule with a transfer pending on the same edge
    kick(128'hfeedface_0badf00d_12345678_9abcdef0);
    stream(128'hfeedface_0badf00d_12345678_9abcdef0, 1'b0, 4);
    rk_ready = 1'b1;
    key_in = 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 restart round", {124'd0, rk_round}, 128'd0);
    chk("R9 restart data", rk_data, 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c);
    chk("R8 last kept on restart", last_key, last_exp);
    stream(128'h2b7e1516_28aed2a6_abf71588_09cf4f3c, 1'b1, 99);

    // random keys with random back-pressure
    for (int n = 0; n < 24; n++) begin
      logic [127:0] k;
      k = {$urandom, $urandom, $urandom, $urandom};
      kick(k);
      stream(k, 1'b1, 99);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule